// File: doc/BRIEF.md
# Combined-Format Two-Wire Register Reader with Arbitration

This block is a two-wire bus master that performs a register read from a serial memory-style target as a single transaction that no other master can break into. The target address, a location byte and a byte count are loaded with a one-cycle start strobe. The block then sends the header with the write direction and the location byte. Without releasing the bus, it issues a repeated start and the header with the read direction. It reads the requested number of bytes and finishes with a stop. Each received byte appears on a data port together with a one-cycle valid strobe.

The bus lines are open-drain. For each of SCL and SDA the block drives an active-high enable that pulls the wire low, and it reads back the resolved level of the wire. A small monitor watches the wires for start and stop conditions and keeps a bus-free flag, so the block never begins while another master owns the bus.

Every bit the block transmits is compared with the wire while SCL is high. If the block releases SDA and sees it low, it has lost arbitration: it lets go of both lines and raises a flag. A configuration input selects what follows. The block either goes idle, or it waits for the bus to become free and replays the whole transaction from a fresh start.

Top module: `i2c_combined_reader`

## Requirements
- R1: A command produces this sequence on the bus: start; 7-bit address sent MSB first followed by direction bit 0 (write); location byte MSB first; repeated start; the same address followed by direction bit 1 (read); `cmd_len` data bytes (`cmd_len` at least 1); stop. Each byte is followed by an acknowledge bit, and SDA low on that bit means acknowledge.
- R2: A successful transaction contains exactly two start conditions and one stop condition. `busy` rises once at the first start and stays high through the repeated start until the stop has completed.
- R3: After every received data byte except the last, the block pulls SDA low on the acknowledge bit. After the last byte it leaves SDA released (no acknowledge).
- R4: Each received byte is presented on `rd_data`, assembled MSB first, with `rd_valid` high for one cycle. `rd_valid` is only ever high while `busy` is high.
- R5: If the target does not acknowledge the write header, the location byte or the read header, the block issues a stop, sets `nack` and pulses `done`, and delivers no data bytes.
- R6: The block keeps a bus-free flag. The flag clears on any start condition seen on the wires and sets on a stop condition (SDA rising while SCL is high). The block issues a start only while the flag is set. While `busy` is low, neither line enable is asserted.
- R7: While transmitting a 1 on an address bit, a direction bit or a location bit, sampling SDA low during the SCL-high phase means lost arbitration. In the cycle `arb_lost` rises, both line enables are already low and `busy` is low. `done` does not pulse.
- R8: If another master drives the same bit values, no contention is detected and the transaction completes normally.
- R9: With `cfg_retry` high, a lost transaction is repeated from a new start once a stop has been seen, and it ends with `done`. With `cfg_retry` low, the block returns to idle.
- R10: One bit period is 4*DIV clocks. Between two consecutive SCL rises within a transaction there are exactly 4*DIV clocks. SDA changes during SCL high only to form start, repeated start and stop conditions.
- R11: `done` is a one-cycle pulse. `nack` and `arb_lost` hold their value until the next command is accepted, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle strobe; accepted only when idle |
| cmd_addr | input | 7 | Target address |
| cmd_loc | input | 8 | Location byte sent in the write phase |
| cmd_len | input | LEN_W | Number of bytes to read (at least 1) |
| cfg_retry | input | 1 | 1: replay after lost arbitration; 0: go idle |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| done | output | 1 | One-cycle pulse when the closing stop finishes |
| nack | output | 1 | Target did not acknowledge a header or location byte |
| arb_lost | output | 1 | Arbitration was lost during the last command |
| busy | output | 1 | Block owns the bus |
| scl_oe | output | 1 | Pull SCL low |
| scl_in | input | 1 | Resolved SCL level |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | Resolved SDA level |

## Verification
A competing master on the wired-AND bus forces SDA low on chosen bits: an address bit, the read-direction bit after the repeated start, and a location bit. A design that skipped the comparison on any of these bits would keep driving and corrupt the other master's frame, and a design that did not release the lines would hold SCL low. The same competitor also matches a 0 bit, which would expose a design that flags contention on agreement. Separate cases cover several other failure modes:
- A design that used a stop and a fresh start between the two phases would show up as an extra stop.
- A design that acknowledged every data byte would show up in the target's tally of acknowledge bits.
- A design that started while another master held the bus would show up as activity on its enables during that hold.

// File: rtl/i2c_combined_reader.sv
module i2c_combined_reader #(
  parameter int DIV   = 4,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [6:0]       cmd_addr,
  input  logic [7:0]       cmd_loc,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cfg_retry,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             nack,
  output logic             arb_lost,
  output logic             busy,
  output logic             scl_oe,
  input  logic             scl_in,
  output logic             sda_oe,
  input  logic             sda_in
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_START, S_BYTE, S_RSTART, S_STOP} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [1:0]       q, seg;
  logic [3:0]       bitn;
  logic [7:0]       sh, loc_r;
  logic [6:0]       addr_r;
  logic [LEN_W-1:0] left, len_r;
  logic             ackbit, scl_q, sda_q, bus_free, in_byte;

  wire tick     = (cnt == CW'(DIV - 1));
  wire tx       = (seg != 2'd3);
  wire start_ev = scl_in && scl_q && sda_q && !sda_in;
  wire stop_ev  = scl_in && scl_q && !sda_q && sda_in;
  assign in_byte = (st == S_BYTE);
  wire lose     = in_byte && tick && q == 2'd2 && tx && bitn < 4'd8 && sh[7] && !sda_in;

  assign busy = st inside {S_START, S_BYTE, S_RSTART, S_STOP};

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START:  begin scl_oe = (q == 2'd3);               sda_oe = q[1];  end
      S_RSTART: begin scl_oe = (q == 2'd0 || q == 2'd3);  sda_oe = q[1];  end
      S_STOP:   begin scl_oe = (q == 2'd0);               sda_oe = !q[1]; end
      S_BYTE: begin
        scl_oe = (q == 2'd0 || q == 2'd3);
        sda_oe = (bitn == 4'd8) ? (!tx && left != LEN_W'(1)) : (tx && !sh[7]);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; q <= '0; seg <= '0; bitn <= '0; sh <= '0;
      left <= '0; len_r <= '0; addr_r <= '0; loc_r <= '0; ackbit <= 1'b0;
      scl_q <= 1'b1; sda_q <= 1'b1; bus_free <= 1'b1;
      rd_data <= '0; rd_valid <= 1'b0; done <= 1'b0; nack <= 1'b0; arb_lost <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      scl_q    <= scl_in;
      sda_q    <= sda_in;
      if (start_ev)     bus_free <= 1'b0;
      else if (stop_ev) bus_free <= 1'b1;

      if (st == S_IDLE || st == S_WAIT) begin
        cnt <= '0;
        q   <= '0;
      end else begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) q <= q + 2'd1;
      end

      case (st)
        S_IDLE: if (cmd_start) begin
          addr_r <= cmd_addr; loc_r <= cmd_loc; len_r <= cmd_len;
          nack <= 1'b0; arb_lost <= 1'b0;
          st <= S_WAIT;
        end
        S_WAIT: if (bus_free) st <= S_START;
        S_START: if (tick && q == 2'd3) begin
          st <= S_BYTE; seg <= 2'd0; bitn <= '0; sh <= {addr_r, 1'b0}; left <= len_r;
        end
        S_RSTART: if (tick && q == 2'd3) begin
          st <= S_BYTE; seg <= 2'd2; bitn <= '0; sh <= {addr_r, 1'b1};
        end
        S_BYTE: begin
          if (lose) begin
            arb_lost <= 1'b1;
            st <= cfg_retry ? S_WAIT : S_IDLE;
          end else if (tick && q == 2'd2) begin
            if (!tx && bitn < 4'd8) sh <= {sh[6:0], sda_in};
            if (bitn == 4'd8) ackbit <= sda_in;
          end else if (tick && q == 2'd3) begin
            if (bitn < 4'd8) begin
              bitn <= bitn + 4'd1;
              if (tx) sh <= {sh[6:0], 1'b0};
              if (!tx && bitn == 4'd7) begin
                rd_data  <= sh;
                rd_valid <= 1'b1;
              end
            end else begin
              bitn <= '0;
              if (tx && ackbit) begin
                nack <= 1'b1;
                st   <= S_STOP;
              end else begin
                case (seg)
                  2'd0: begin seg <= 2'd1; sh <= loc_r; end
                  2'd1: st <= S_RSTART;
                  2'd2: seg <= 2'd3;
                  default: if (left == LEN_W'(1)) st <= S_STOP;
                           else left <= left - 1'b1;
                endcase
              end
            end
          end
        end
        S_STOP: if (tick && q == 2'd3) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_combined_reader_chk.sv
module i2c_combined_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sda_oe,
  input logic scl_oe,
  input logic scl_in,
  input logic arb_lost,
  input logic done,
  input logic rd_valid,
  input logic bus_free,
  input logic in_byte
);
  a_r10_sda_steady_while_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (in_byte && $past(in_byte) && scl_in && $past(scl_in)) |-> $stable(sda_oe));

  a_r7_lines_free_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> (!sda_oe && !scl_oe && !busy));

  a_r6_start_needs_free_bus: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_free));

  a_r6_quiet_when_not_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sda_oe && !scl_oe));

  a_r11_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_valid_inside_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);
endmodule

bind i2c_combined_reader i2c_combined_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .scl_in(scl_in), .arb_lost(arb_lost), .done(done), .rd_valid(rd_valid),
  .bus_free(bus_free), .in_byte(in_byte)
);

// File: tb/i2c_combined_reader_test.sv
module i2c_combined_reader_test;
  localparam int DIV = 4;
  localparam logic [6:0] TADDR = 7'h50;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, cmd_start = 1'b0, cfg_retry = 1'b0;
  logic [6:0] cmd_addr = '0;
  logic [7:0] cmd_loc = '0;
  logic [3:0] cmd_len = '0;
  wire  [7:0] rd_data;
  wire rd_valid, done, nack, arb_lost, busy, scl_oe, sda_oe;

  logic t_drv = 1'b0, c_sda = 1'b0, c_scl = 1'b0, c_force = 1'b0;
  logic c_arm = 1'b0, c_hold = 1'b0;
  int   c_k = 0;
  wire scl_w = ~(scl_oe | c_scl);
  wire sda_w = ~(sda_oe | t_drv | c_sda | c_force);

  i2c_combined_reader #(.DIV(DIV), .LEN_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .cmd_loc(cmd_loc), .cmd_len(cmd_len), .cfg_retry(cfg_retry),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .nack(nack),
    .arb_lost(arb_lost), .busy(busy), .scl_oe(scl_oe), .scl_in(scl_w),
    .sda_oe(sda_oe), .sda_in(sda_w));

  function automatic logic [7:0] memf(input logic [7:0] p);
    return p * 8'd7 + 8'd3;
  endfunction

  // bus observer
  logic scl_p = 1'b1, sda_p = 1'b1, tb_free = 1'b1, busy_p = 1'b0, have_rise = 1'b0;
  int n_start = 0, n_stop = 0, rises = 0, n_brise = 0, cyc = 0, last_rise = 0;
  int gmin = 0, gmax = 0;
  wire start_ev = scl_p && scl_w && sda_p && !sda_w;
  wire stop_ev  = scl_p && scl_w && !sda_p && sda_w;
  wire rise_ev  = !scl_p && scl_w;
  wire fall_ev  = scl_p && !scl_w;

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    scl_p  <= scl_w;
    sda_p  <= sda_w;
    busy_p <= busy;
    if (busy && !busy_p) n_brise <= n_brise + 1;
    if (start_ev) begin
      n_start <= n_start + 1;
      tb_free <= 1'b0;
      if (tb_free) begin rises <= 0; have_rise <= 1'b0; gmin <= 1000000; gmax <= 0; end
    end
    if (stop_ev) begin n_stop <= n_stop + 1; tb_free <= 1'b1; end
    if (rise_ev) begin
      rises <= rises + 1;
      last_rise <= cyc;
      have_rise <= 1'b1;
      if (have_rise) begin
        if (cyc - last_rise < gmin) gmin <= cyc - last_rise;
        if (cyc - last_rise > gmax) gmax <= cyc - last_rise;
      end
    end
  end

  // memory-style target
  int tmode = 0, bcnt = 0, n_mack = 0, n_mnack = 0;
  logic [7:0] tsh = '0, ptr = '0;
  logic is_addr = 1'b0, rdir = 1'b0, mack = 1'b0;
  always @(posedge clk) begin
    if (start_ev) begin
      tmode <= 1; is_addr <= 1'b1; bcnt <= 0; t_drv <= 1'b0;
    end else if (stop_ev) begin
      tmode <= 0; t_drv <= 1'b0;
    end else if (rise_ev) begin
      if (tmode == 1 && bcnt < 8) begin tsh <= {tsh[6:0], sda_w}; bcnt <= bcnt + 1; end
      if (tmode == 2) begin
        if (bcnt < 8) begin tsh <= {tsh[6:0], 1'b0}; bcnt <= bcnt + 1; end
        else if (bcnt == 9) begin
          mack <= !sda_w;
          if (!sda_w) n_mack <= n_mack + 1; else n_mnack <= n_mnack + 1;
        end
      end
    end else if (fall_ev) begin
      if (tmode == 1) begin
        if (bcnt == 8) begin
          if (is_addr) begin
            if (tsh[7:1] == TADDR) begin t_drv <= 1'b1; rdir <= tsh[0]; bcnt <= 9; end
            else tmode <= 0;
          end else begin ptr <= tsh; t_drv <= 1'b1; bcnt <= 9; end
        end else if (bcnt == 9) begin
          if (is_addr && rdir) begin
            tmode <= 2; tsh <= memf(ptr); t_drv <= !memf(ptr)[7]; ptr <= ptr + 8'd1; bcnt <= 0;
          end else begin
            t_drv <= 1'b0; is_addr <= 1'b0; bcnt <= 0;
          end
        end
      end else if (tmode == 2) begin
        if (bcnt < 8) t_drv <= !tsh[7];
        else if (bcnt == 8) begin t_drv <= 1'b0; bcnt <= 9; end
        else if (mack) begin
          tsh <= memf(ptr); t_drv <= !memf(ptr)[7]; ptr <= ptr + 8'd1; bcnt <= 0;
        end else begin tmode <= 0; t_drv <= 1'b0; end
      end
    end
  end

  // competing master: pulls SDA low from the SCL fall after c_k rises
  always @(posedge clk) begin
    if (!c_arm) c_sda <= 1'b0;
    else if (fall_ev && rises == c_k) c_sda <= 1'b1;
    else if (fall_ev && !c_hold && rises == c_k + 1) c_sda <= 1'b0;
  end

  // scoreboard
  logic [7:0] exp_q[$];
  int sb_checks = 0, sb_fail = 0;
  always @(negedge clk) begin
    if (rd_valid) begin
      sb_checks <= sb_checks + 1;
      if (exp_q.size() == 0) begin
        sb_fail <= sb_fail + 1;
        $display("FAIL R4 unexpected byte actual=%0d expected=none", rd_data);
      end else begin
        if (rd_data != exp_q[0]) begin
          sb_fail <= sb_fail + 1;
          $display("FAIL R1 data byte actual=%0d expected=%0d", rd_data, exp_q[0]);
        end
        void'(exp_q.pop_front());
      end
    end
  end

  int n_checks = 0, n_fail = 0;
  int s_start, s_stop, s_brise, s_mack, s_mnack;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic snap();
    s_start = n_start; s_stop = n_stop; s_brise = n_brise; s_mack = n_mack; s_mnack = n_mnack;
  endtask

  task automatic issue(input logic [6:0] a, input logic [7:0] l, input logic [3:0] n,
                       input logic r, input bit expect_data);
    if (expect_data) for (int i = 0; i < n; i++) exp_q.push_back(memf(l + 8'(i)));
    snap();
    @(negedge clk);
    cmd_addr = a; cmd_loc = l; cmd_len = n; cfg_retry = r; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_lost(output bit got);
    got = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (arb_lost) begin got = 1'b1; break; end
    end
  endtask

  task automatic comp_stop();
    repeat (10) @(negedge clk); c_scl = 1'b1;
    repeat (20) @(negedge clk); c_scl = 1'b0;
    repeat (20) @(negedge clk); c_scl = 1'b1;
    repeat (20) @(negedge clk); c_scl = 1'b0;
    repeat (20) @(negedge clk); c_arm = 1'b0; c_hold = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks + sb_checks, n_fail + sb_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_checks + sb_checks + 1, n_fail + sb_fail + 1);
    $finish;
  end

  initial begin
    bit got;
    bit quiet;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 reset busy", busy, 0);
    check("R6 reset enables", {scl_oe, sda_oe}, 0);
    check("R11 reset flags", {done, nack, arb_lost}, 0);

    // R1 R2 R3 R10: single byte
    issue(TADDR, 8'h35, 4'd1, 1'b0, 1);
    wait_done(got);
    check("R11 done pulse single", got, 1);
    check("R1 all bytes delivered", exp_q.size(), 0);
    check("R2 start count", n_start - s_start, 2);
    check("R2 stop count", n_stop - s_stop, 1);
    check("R2 busy rises once", n_brise - s_brise, 1);
    check("R3 acks single", n_mack - s_mack, 0);
    check("R3 final nack single", n_mnack - s_mnack, 1);
    check("R10 min SCL period", gmin, 4 * DIV);
    check("R10 max SCL period", gmax, 4 * DIV);
    check("R5 no nack flag", nack, 0);

    // R3 R4: three bytes with location wrap
    issue(TADDR, 8'hFE, 4'd3, 1'b0, 1);
    wait_done(got);
    check("R4 done three", got, 1);
    check("R4 all three delivered", exp_q.size(), 0);
    check("R3 acks three", n_mack - s_mack, 2);
    check("R3 final nack three", n_mnack - s_mnack, 1);
    check("R2 stop count three", n_stop - s_stop, 1);

    // R1: five bytes from zero
    issue(TADDR, 8'h00, 4'd5, 1'b0, 1);
    wait_done(got);
    check("R1 done five", got, 1);
    check("R1 all five delivered", exp_q.size(), 0);
    check("R3 acks five", n_mack - s_mack, 4);

    // R5: no target at this address
    issue(7'h51, 8'h10, 4'd2, 1'b0, 0);
    wait_done(got);
    check("R5 done on nack", got, 1);
    check("R5 nack flag", nack, 1);
    check("R5 one start only", n_start - s_start, 1);
    check("R5 stop issued", n_stop - s_stop, 1);
    check("R5 busy released", busy, 0);

    // R11: next command clears nack
    issue(TADDR, 8'h40, 4'd1, 1'b0, 1);
    wait_done(got);
    check("R11 nack cleared", nack, 0);
    check("R11 done after nack", got, 1);

    // R6: another master holds the bus
    c_force = 1'b1;
    repeat (10) @(negedge clk);
    issue(TADDR, 8'h22, 4'd2, 1'b0, 1);
    quiet = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (busy || scl_oe || sda_oe) quiet = 1'b0;
    end
    check("R6 no drive while bus held", quiet, 1);
    c_force = 1'b0;
    wait_done(got);
    check("R6 starts after stop seen", got, 1);
    check("R6 data after wait", exp_q.size(), 0);

    // R7: lost on address bit 2
    c_k = 2; c_hold = 1'b1; c_arm = 1'b1;
    issue(TADDR, 8'h35, 4'd1, 1'b0, 0);
    wait_lost(got);
    check("R7 loss on address bit", got, 1);
    @(negedge clk);
    check("R7 lines released addr", {scl_oe, sda_oe, busy}, 0);
    comp_stop();
    check("R9 idle without retry", busy, 0);
    check("R7 no done addr", done, 0);

    // R7: lost on location bit 2
    c_k = 11; c_hold = 1'b1; c_arm = 1'b1;
    issue(TADDR, 8'h35, 4'd1, 1'b0, 0);
    wait_lost(got);
    check("R7 loss on location bit", got, 1);
    @(negedge clk);
    check("R7 lines released loc", {scl_oe, sda_oe, busy}, 0);
    comp_stop();
    repeat (200) @(negedge clk);
    check("R9 stays idle", busy, 0);

    // R11: flag cleared by next command
    issue(TADDR, 8'h60, 4'd1, 1'b0, 1);
    wait_done(got);
    check("R11 arb_lost cleared", arb_lost, 0);

    // R8: competitor matches a 0 address bit
    c_k = 1; c_hold = 1'b0; c_arm = 1'b1;
    issue(TADDR, 8'h77, 4'd2, 1'b0, 1);
    wait_done(got);
    c_arm = 1'b0;
    check("R8 no loss on equal bits", arb_lost, 0);
    check("R8 completes", got, 1);
    check("R8 data intact", exp_q.size(), 0);

    // R7 R9: lost on read direction bit, then replay
    c_k = 26; c_hold = 1'b1; c_arm = 1'b1;
    issue(TADDR, 8'h90, 4'd2, 1'b1, 1);
    wait_lost(got);
    check("R7 loss on direction bit", got, 1);
    @(negedge clk);
    check("R7 lines released dir", {scl_oe, sda_oe}, 0);
    comp_stop();
    wait_done(got);
    check("R9 replay completes", got, 1);
    check("R9 replay data", exp_q.size(), 0);
    check("R11 arb_lost held", arb_lost, 1);

    summary();
    $finish;
  end
endmodule